// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block schedules conversions for an 8-bit converter shared across thirteen analog channels. Channels 0 to 11 are fixed supply measurements. Channel 12 is routed to one of three general-purpose inputs through a 2-bit front-end select. In free-running mode the sequencer launches one conversion per channel in ascending order. It stores each result in that channel's own data register, and it begins a new scan once every `SCAN_PERIOD` clock cycles. The default value stands for the 665 ms update interval in scaled form.

A host stops the scan by raising `halt_scan`. Any conversion already in flight completes and is stored first. The sequencer then goes quiescent and the status busy bit reads 0. While quiescent, the host starts single conversions by writing a channel number to the channel-address register, and it watches the busy bit to see when each one is done. It may also write the data registers directly for software testing. Lowering `halt_scan` resumes scanning at channel 0. The block is held in reset whenever `rst_n` is low or `supply_ok` reports that the internal supply is not valid.

The controller has five states. ST_PREP restarts the period timer and leaves on the next edge, to ST_LAUNCH at channel 0, or to ST_QUIET if halted. ST_LAUNCH pulses the converter start and always moves to ST_CONVERT. ST_CONVERT waits for done and stores the result. From there it goes to ST_QUIET after a single-shot conversion or when halted, to ST_WAIT after channel 12, and otherwise back to ST_LAUNCH with the next channel. ST_WAIT waits for the period timer to expire and then returns to ST_LAUNCH at channel 0, or it goes to ST_QUIET if halted. ST_QUIET returns to ST_PREP when the halt is released, or it goes to ST_LAUNCH on an accepted channel-address write. Reset enters ST_PREP.

Top module: `adcseq_top`

## Requirements
- R1: A free-running scan launches channels 0,1,...,12 in that order. During the channel 12 conversion, `fe_gpio_sel` shows `gpio_pick` as sampled before that conversion, and it holds steady until done. Pick values 0 to 2 pass through unchanged, and the reserved value 3 is presented as 0.
- R2: The result of each conversion is stored in the data register of the converted channel. Host address N (0 to 12) reads data register N on `hst_rdata` combinationally.
- R3: In free-running mode, consecutive starts of channel 0 are exactly `SCAN_PERIOD` cycles apart.
- R4: After `halt_scan` rises, the conversion in progress completes and is stored, and no further conversion is launched. Host address 16 reads status with bit 7 = busy and bit 0 = quiescent, so a quiescent idle sequencer reads 8'h01.
- R5: While quiescent, a host write of a value 0 to 12 to address 16 starts exactly one conversion of that channel. Busy reads 1 from the cycle after the write until the edge at which the result is stored.
- R6: After a single conversion completes, writing the same or another channel number to address 16 starts another single conversion.
- R7: A write to address 16 is ignored while busy, while free-running, or when the value is above 12.
- R8: While quiescent, host writes to addresses 0 to 12 replace the data register. At any other time such writes are ignored.
- R9: Lowering `halt_scan` resumes free-running scanning, always beginning at channel 0.
- R10: While `rst_n` or `supply_ok` is low, all data registers read 0 and `cv_start` stays low. After release, scanning begins at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Internal supply valid; low holds the block in reset |
| halt_scan | input | 1 | Control bit: 1 stops free-running mode |
| gpio_pick | input | 2 | Selects which general-purpose input feeds channel 12 |
| cv_start | output | 1 | One-cycle converter start pulse |
| cv_sel | output | 4 | Channel being converted |
| fe_gpio_sel | output | 2 | Front-end mux select for channel 12 |
| cv_done | input | 1 | Converter result valid pulse |
| cv_data | input | 8 | Converter result |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | 5 | Host register address (0-12 data, 16 channel address/status) |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |

## Verification
The bench raises the halt exactly while channel 5 is in flight. A design that abandoned that conversion would leave register 5 stale, and one that kept scanning would overwrite register 6. The bench issues channel-address writes while busy, while free-running and with out-of-range values. A design that accepted any of them would produce extra start pulses, which the scoreboard rejects. The bench also checks scan spacing, the resume at channel 0 after both a halt and a supply drop, and the reserved GPIO select value. These catch off-by-one timers, resumes from the wrong channel, and a select that drifts during conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int NUM_CH = 13;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int LAST_CH = NUM_CH - 1;

    typedef enum logic [2:0] {
        ST_PREP,
        ST_LAUNCH,
        ST_CONVERT,
        ST_WAIT,
        ST_QUIET
    } seq_state_e;
endpackage

// File: rtl/adcseq_period_timer.sv
module adcseq_period_timer #(
    parameter int PERIOD = 665
) (
    input  logic clk,
    input  logic arst_n,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIMIT);

    // R3: a fresh period never expires on the cycle after restart
    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!arst_n)
        restart |=> !expired);
endmodule

// File: rtl/adcseq_regfile.sv
module adcseq_regfile
    import adcseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              cv_we,
    input  logic [CH_W-1:0]   cv_ch,
    input  logic [DATA_W-1:0] cv_wd,
    input  logic              host_we,
    input  logic              host_ok,
    input  logic [CH_W-1:0]   host_ch,
    input  logic [DATA_W-1:0] host_wd,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                slot_q[g] <= '0;
            end else if (cv_we && cv_ch == CH_W'(g)) begin
                slot_q[g] <= cv_wd;
            end else if (host_we && host_ok && host_ch == CH_W'(g)) begin
                slot_q[g] <= host_wd;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i)) rd_data = slot_q[i];
        end
    end

    // R2: a converter result lands in the slot of its channel
    assert_store_lands_R2: assert property (@(posedge clk) disable iff (!arst_n)
        (cv_we && cv_ch == CH_W'(0)) |=> (slot_q[0] == $past(cv_wd)));
    assert_store_last_R2: assert property (@(posedge clk) disable iff (!arst_n)
        (cv_we && cv_ch == CH_W'(LAST_CH)) |=> (slot_q[LAST_CH] == $past(cv_wd)));
endmodule

// File: rtl/adcseq_gpio_hold.sv
module adcseq_gpio_hold
    import adcseq_pkg::*;
(
    input  logic            clk,
    input  logic            arst_n,
    input  logic            busy,
    input  logic [CH_W-1:0] cur_ch,
    input  logic [1:0]      gpio_pick,
    output logic [1:0]      fe_sel
);
    logic hold;
    logic [1:0] pick_legal;

    assign hold       = busy && (cur_ch == CH_W'(LAST_CH));
    assign pick_legal = (gpio_pick == 2'd3) ? 2'd0 : gpio_pick;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            fe_sel <= 2'd0;
        end else if (!hold) begin
            fe_sel <= pick_legal;
        end
    end

    // R1: select stays put for the whole channel 12 conversion
    assert_gsel_stable_R1: assert property (@(posedge clk) disable iff (!arst_n)
        (hold && $past(hold)) |-> $stable(fe_sel));
    assert_gsel_legal_R1: assert property (@(posedge clk) disable iff (!arst_n)
        fe_sel != 2'd3);
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              halt_scan,
    input  logic              trig_req,
    input  logic [DATA_W-1:0] trig_val,
    input  logic              cv_done,
    input  logic              period_expired,
    output logic              period_restart,
    output logic              cv_start,
    output logic [CH_W-1:0]   cur_ch,
    output logic              busy,
    output logic              quiet,
    output logic              store_en
);
    seq_state_e state_q, state_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic single_q, single_d;
    logic trig_ok;

    assign trig_ok = trig_req && halt_scan && (trig_val < DATA_W'(NUM_CH));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q  <= ST_PREP;
            ch_q     <= '0;
            single_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            ch_q     <= ch_d;
            single_q <= single_d;
        end
    end

    always_comb begin
        state_d        = state_q;
        ch_d           = ch_q;
        single_d       = single_q;
        period_restart = 1'b0;
        unique case (state_q)
            ST_PREP: begin
                if (halt_scan) begin
                    state_d = ST_QUIET;
                end else begin
                    state_d        = ST_LAUNCH;
                    ch_d           = '0;
                    single_d       = 1'b0;
                    period_restart = 1'b1;
                end
            end
            ST_LAUNCH: begin
                state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (cv_done) begin
                    if (single_q || halt_scan) begin
                        state_d  = ST_QUIET;
                        single_d = 1'b0;
                    end else if (ch_q == CH_W'(LAST_CH)) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_LAUNCH;
                        ch_d    = ch_q + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (halt_scan) begin
                    state_d = ST_QUIET;
                end else if (period_expired) begin
                    state_d        = ST_LAUNCH;
                    ch_d           = '0;
                    period_restart = 1'b1;
                end
            end
            ST_QUIET: begin
                if (!halt_scan) begin
                    state_d = ST_PREP;
                end else if (trig_ok) begin
                    state_d  = ST_LAUNCH;
                    ch_d     = trig_val[CH_W-1:0];
                    single_d = 1'b1;
                end
            end
            default: state_d = ST_PREP;
        endcase
    end

    always_comb begin
        cv_start = (state_q == ST_LAUNCH);
        busy     = (state_q == ST_LAUNCH) || (state_q == ST_CONVERT);
        quiet    = (state_q == ST_QUIET);
        store_en = (state_q == ST_CONVERT) && cv_done;
        cur_ch   = ch_q;
    end

    assert_sel_range_R1: assert property (@(posedge clk) disable iff (!arst_n)
        cv_start |-> (cur_ch < CH_W'(NUM_CH)));
    assert_busy_until_done_R5: assert property (@(posedge clk) disable iff (!arst_n)
        (busy && !cv_done) |=> busy);
    assert_resume_ch0_R9: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_PREP && !halt_scan) |=> (cv_start && cur_ch == '0));
    assert_halt_stops_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (store_en && halt_scan) |=> !busy);
    assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!arst_n)
        (busy && !cv_done && trig_req) |=> $stable(cur_ch));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SCAN_PERIOD = 665,
    parameter int ADDR_W      = 5,
    parameter int CMD_ADDR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              halt_scan,
    input  logic [1:0]        gpio_pick,
    output logic              cv_start,
    output logic [CH_W-1:0]   cv_sel,
    output logic [1:0]        fe_gpio_sel,
    input  logic              cv_done,
    input  logic [DATA_W-1:0] cv_data,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata
);
    logic arst_n;
    logic busy, quiet, store_en;
    logic period_restart, period_expired;
    logic is_data_addr, is_cmd_addr;
    logic [DATA_W-1:0] slot_rd;
    logic [DATA_W-1:0] status;

    assign arst_n       = rst_n & supply_ok;
    assign is_data_addr = (hst_addr < ADDR_W'(NUM_CH));
    assign is_cmd_addr  = (hst_addr == ADDR_W'(CMD_ADDR));

    adcseq_period_timer #(.PERIOD(SCAN_PERIOD)) timer_i (
        .clk     (clk),
        .arst_n  (arst_n),
        .restart (period_restart),
        .expired (period_expired)
    );

    adcseq_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk            (clk),
        .arst_n         (arst_n),
        .halt_scan      (halt_scan),
        .trig_req       (hst_we && is_cmd_addr),
        .trig_val       (hst_wdata),
        .cv_done        (cv_done),
        .period_expired (period_expired),
        .period_restart (period_restart),
        .cv_start       (cv_start),
        .cur_ch         (cv_sel),
        .busy           (busy),
        .quiet          (quiet),
        .store_en       (store_en)
    );

    adcseq_regfile #(.DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .arst_n  (arst_n),
        .cv_we   (store_en),
        .cv_ch   (cv_sel),
        .cv_wd   (cv_data),
        .host_we (hst_we && is_data_addr),
        .host_ok (quiet && halt_scan),
        .host_ch (hst_addr[CH_W-1:0]),
        .host_wd (hst_wdata),
        .rd_ch   (hst_addr[CH_W-1:0]),
        .rd_data (slot_rd)
    );

    adcseq_gpio_hold gsel_i (
        .clk       (clk),
        .arst_n    (arst_n),
        .busy      (busy),
        .cur_ch    (cv_sel),
        .gpio_pick (gpio_pick),
        .fe_sel    (fe_gpio_sel)
    );

    always_comb begin
        status           = '0;
        status[DATA_W-1] = busy;
        status[0]        = quiet;
        if (is_data_addr)      hst_rdata = slot_rd;
        else if (is_cmd_addr)  hst_rdata = status;
        else                   hst_rdata = '0;
    end

    // R10: no launch can appear while held in reset
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !arst_n |-> !cv_start);
endmodule

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
    localparam int PER = 200;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, supply_ok = 1'b1, halt_scan = 1'b0;
    logic [1:0] gpio_pick = 2'd2;
    logic cv_start, cv_done = 1'b0;
    logic [3:0] cv_sel;
    logic [1:0] fe_gpio_sel;
    logic [7:0] cv_data = '0;
    logic hst_we = 1'b0;
    logic [4:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0, hst_rdata;

    int n_run = 0, n_fail = 0, n_starts = 0, cyc = 0, tag = 1, resp_cnt = 0;
    int exp_q[$];
    int t0[$];
    logic [7:0] expv [13];
    logic [1:0] gsel_seen = '0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    adcseq_top #(.SCAN_PERIOD(PER)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .halt_scan(halt_scan),
        .gpio_pick(gpio_pick), .cv_start(cv_start), .cv_sel(cv_sel),
        .fe_gpio_sel(fe_gpio_sel), .cv_done(cv_done), .cv_data(cv_data),
        .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata));

    function automatic logic [7:0] ev(int ch, logic [1:0] g, int t);
        if (ch == 12) return {2'b11, g, 4'(t)};
        return {4'(ch), 4'(t)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // converter responder
    always @(negedge clk) begin
        cv_done <= 1'b0;
        if (resp_cnt > 0) begin
            if (resp_cnt == 1) begin
                cv_done <= 1'b1;
                cv_data <= ev(int'(cv_sel), gsel_seen, tag);
                expv[cv_sel] = ev(int'(cv_sel), gsel_seen, tag);
            end
            resp_cnt = resp_cnt - 1;
        end
        if (cv_start) begin
            resp_cnt = LAT;
            gsel_seen = fe_gpio_sel;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (cv_start) begin
            n_starts++;
            if (cv_sel == 4'd0 && !halt_scan) t0.push_back(cyc);
            if (exp_q.size() == 0) begin
                check(0, "R1/R7 unexpected start", int'(cv_sel), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(cv_sel) == e, "R1 channel order", int'(cv_sel), e);
            end
        end
    end

    task automatic push_scan();
        for (int c = 0; c < 13; c++) exp_q.push_back(c);
    endtask

    task automatic hw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic hr(input logic [4:0] a, output logic [7:0] d);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic wait_starts(int n);
        while (n_starts < n) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int s;
        for (int c = 0; c < 13; c++) expv[c] = '0;
        repeat (3) @(negedge clk);
        hr(5'd0, d);
        check(d == 8'h00 && !cv_start, "R10 reset state", d, 0);
        push_scan();
        rst_n = 1'b1;
        wait_starts(13);
        for (int c = 0; c < 13; c++) begin
            hr(5'(c), d);
            check(d == expv[c], "R2 scan result", d, expv[c]);
        end
        check(expv[12] == ev(12, 2'd2, 1), "R1 gpio select 2", expv[12], ev(12, 2'd2, 1));
        // second scan, reserved pick value
        tag = 2; gpio_pick = 2'd3;
        push_scan();
        wait_starts(26);
        check(t0.size() >= 2 && t0[1] - t0[0] == PER, "R3 scan spacing",
              t0.size() >= 2 ? t0[1] - t0[0] : 0, PER);
        check(expv[12] == ev(12, 2'd0, 2), "R1 reserved pick", expv[12], ev(12, 2'd0, 2));
        // writes during free-running mode
        s = n_starts;
        hw(5'd4, 8'h5A);
        hw(5'd16, 8'd3);
        repeat (10) @(negedge clk);
        check(n_starts == s, "R7 trigger while free-running", n_starts, s);
        hr(5'd4, d);
        check(d == ev(4, 2'd0, 2), "R8 data write while free-running", d, ev(4, 2'd0, 2));
        // halt in the middle of channel 5
        tag = 3;
        push_scan();
        while (!(cv_start && cv_sel == 4'd5)) @(negedge clk);
        halt_scan = 1'b1;
        repeat (20) @(negedge clk);
        exp_q.delete();
        s = n_starts;
        repeat (20) @(negedge clk);
        check(n_starts == s, "R4 no launch after halt", n_starts, s);
        hr(5'd5, d);
        check(d == ev(5, 2'd0, 3), "R4 in-flight stored", d, ev(5, 2'd0, 3));
        hr(5'd6, d);
        check(d == ev(6, 2'd0, 2), "R4 next channel untouched", d, ev(6, 2'd0, 2));
        hr(5'd16, d);
        check(d == 8'h01, "R4 quiescent status", d, 8'h01);
        // host data write while quiescent
        hw(5'd3, 8'hA5);
        hr(5'd3, d);
        check(d == 8'hA5, "R8 quiescent data write", d, 8'hA5);
        // single shot with a write while busy
        tag = 4; s = n_starts;
        exp_q.push_back(9);
        hw(5'd16, 8'd9);
        hr(5'd16, d);
        check(d[7] == 1'b1, "R5 busy after trigger", d, 8'h80);
        hw(5'd16, 8'd7);
        repeat (12) @(negedge clk);
        check(n_starts == s + 1, "R5/R7 one conversion only", n_starts, s + 1);
        hr(5'd9, d);
        check(d == ev(9, 2'd0, 4), "R5 single result", d, ev(9, 2'd0, 4));
        hr(5'd7, d);
        check(d == ev(7, 2'd0, 2), "R7 busy trigger ignored", d, ev(7, 2'd0, 2));
        hr(5'd16, d);
        check(d == 8'h01, "R5 busy cleared", d, 8'h01);
        // out of range addresses
        s = n_starts;
        hw(5'd16, 8'd13);
        hw(5'd16, 8'd255);
        repeat (10) @(negedge clk);
        check(n_starts == s, "R7 out of range ignored", n_starts, s);
        // repeat conversions
        tag = 5;
        exp_q.push_back(9);
        hw(5'd16, 8'd9);
        repeat (10) @(negedge clk);
        hr(5'd9, d);
        check(d == ev(9, 2'd0, 5), "R6 same channel again", d, ev(9, 2'd0, 5));
        exp_q.push_back(2);
        hw(5'd16, 8'd2);
        repeat (10) @(negedge clk);
        hr(5'd2, d);
        check(d == ev(2, 2'd0, 5), "R6 other channel", d, ev(2, 2'd0, 5));
        // resume
        tag = 6; s = n_starts;
        push_scan();
        halt_scan = 1'b0;
        wait_starts(s + 13);
        check(exp_q.size() == 0, "R9 resume scan from channel 0", exp_q.size(), 0);
        // supply drop
        @(negedge clk);
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        hr(5'd0, d);
        check(d == 8'h00 && !cv_start, "R10 supply low clears", d, 0);
        exp_q.delete();
        tag = 7; s = n_starts;
        push_scan();
        supply_ok = 1'b1;
        wait_starts(s + 13);
        check(exp_q.size() == 0, "R10 restart at channel 0", exp_q.size(), 0);
        hr(5'd0, d);
        check(d == ev(0, 2'd0, 7), "R10 scan after supply", d, ev(0, 2'd0, 7));
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule